// File: doc/BRIEF.md
# Host and slave interrupt register bank

This block holds the interrupt state shared between a card-side register bus and the logic on the slave side of the device. Slave logic raises any of eight slave-to-host events by pulsing a bit of `set_pulse`. Each event is latched in a status register. The host masks the events with an enable register and retires them by writing ones to a clear register. While any enabled status bit is set, the block drives a registered, active-low, level-sensitive interrupt line toward the host.

In the other direction, the host writes a byte of eight general-purpose bits toward the slave. Every bit written as one appears on `h2s_pulse` for exactly one clock. The bit then clears itself, so this byte reads back as zero afterwards.

The block sees only decoded register accesses: an address, write data, a write strobe and combinational read data. Command framing, CRC and bus timing are handled elsewhere.

Top module: `hsirq_bank`

## Requirements
- R1: After a synchronous reset, the status and enable registers are zero, `s2h_irq_n` is 1 and `h2s_pulse` is zero.
- R2: A one on `set_pulse[i]` in a cycle sets status bit i at that clock edge. Status reads at byte address 0x058 in bits 7:0, and bits 31:8 read as zero.
- R3: A write to address 0x0D4 clears every status bit whose `reg_wdata` bit is 1. Status bits whose write bit is 0 keep their value.
- R4: If a set pulse and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable register is written and read at address 0x0DC in bits 7:0. It changes only on a write to that address.
- R6: `s2h_irq_n` is low exactly when the status AND enable value of the previous cycle is non-zero, so it follows a register change one clock later.
- R7: Masking every pending source through the enable register returns `s2h_irq_n` high and leaves the status bits unchanged.
- R8: A write of value v to address 0x08D drives `h2s_pulse` = v for the single following cycle. In every other cycle `h2s_pulse` is zero.
- R9: Address 0x08D reads back the byte being pulsed in that cycle and reads zero once it has cleared itself.
- R10: Writes to the status address or to unmapped addresses change no state. Reads of the clear address or of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 8 | Write data for the addressed register |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| set_pulse | input | 8 | Per-source set requests from slave logic |
| s2h_irq_n | output | 1 | Registered active-low interrupt toward the host |
| h2s_pulse | output | 8 | One-cycle host-to-slave interrupt bits |

## Verification
The hardest case to reach from the ports is a host clear and a slave set landing on the same status bit in the same clock. Random traffic rarely lines up a clear write with a set pulse on the same bit, so the bench forces this overlap directly. The random phase then draws set pulses on every cycle, including the cycles that carry clear writes, so partial overlaps across several bits occur many times. The one-clock lag of the interrupt line is checked after every cycle against a model that uses the previous cycle's status and enable values.

// File: rtl/hsirq_pkg.sv
package hsirq_pkg;

    parameter int unsigned NSRC   = 8;
    parameter int unsigned ADDR_W = 12;
    parameter int unsigned DATA_W = 32;

    // Byte addresses seen by the host
    localparam logic [ADDR_W-1:0] A_STATUS = 12'h058;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 12'h0D4;
    localparam logic [ADDR_W-1:0] A_ENABLE = 12'h0DC;
    localparam logic [ADDR_W-1:0] A_H2S    = 12'h08D;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CLEAR,
        SEL_ENABLE,
        SEL_H2S
    } reg_sel_e;

    typedef struct packed {
        logic clr_we;
        logic ena_we;
        logic h2s_we;
    } wr_ctl_t;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            A_STATUS: return SEL_STATUS;
            A_CLEAR:  return SEL_CLEAR;
            A_ENABLE: return SEL_ENABLE;
            A_H2S:    return SEL_H2S;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic wr_ctl_t write_controls(input reg_sel_e sel, input logic wr);
        wr_ctl_t c;
        c.clr_we = wr && (sel == SEL_CLEAR);
        c.ena_we = wr && (sel == SEL_ENABLE);
        c.h2s_we = wr && (sel == SEL_H2S);
        return c;
    endfunction

endpackage

// File: rtl/hsirq_status.sv
module hsirq_status #(
    parameter int unsigned NSRC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_i,
    input  logic            clr_we,
    input  logic            ena_we,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] st_o,
    output logic [NSRC-1:0] ena_o
);
    // One flop per source; a set in the same cycle overrides a clear.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                st_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                st_o[i] <= 1'b1;
            end else if (clr_we && wdata[i]) begin
                st_o[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_o <= '0;
        end else if (ena_we) begin
            ena_o <= wdata;
        end
    end
endmodule

// File: rtl/hsirq_line.sv
module hsirq_line #(
    parameter int unsigned NSRC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] st,
    input  logic [NSRC-1:0] ena,
    output logic            irq_n
);
    logic pending;
    assign pending = |(st & ena);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_n <= 1'b1;
        end else begin
            irq_n <= ~pending;
        end
    end
endmodule

// File: rtl/hsirq_h2s.sv
module hsirq_h2s #(
    parameter int unsigned NSRC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] pulse_o
);
    // Holds written ones for one cycle, then clears itself.
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_o <= '0;
        end else if (we) begin
            pulse_o <= wdata;
        end else begin
            pulse_o <= '0;
        end
    end
endmodule

// File: rtl/hsirq_bank.sv
module hsirq_bank
    import hsirq_pkg::*;
#(
    parameter int unsigned NSRC   = hsirq_pkg::NSRC,
    parameter int unsigned DATA_W = hsirq_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NSRC-1:0]   reg_wdata,
    input  logic              reg_wr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]   set_pulse,
    output logic              s2h_irq_n,
    output logic [NSRC-1:0]   h2s_pulse
);
    reg_sel_e        sel;
    wr_ctl_t         ctl;
    logic [NSRC-1:0] st_q;
    logic [NSRC-1:0] ena_q;

    assign sel = decode(reg_addr);
    assign ctl = write_controls(sel, reg_wr);

    hsirq_status #(.NSRC(NSRC)) u_status (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_pulse),
        .clr_we (ctl.clr_we),
        .ena_we (ctl.ena_we),
        .wdata  (reg_wdata),
        .st_o   (st_q),
        .ena_o  (ena_q)
    );

    hsirq_line #(.NSRC(NSRC)) u_line (
        .clk   (clk),
        .rst   (rst),
        .st    (st_q),
        .ena   (ena_q),
        .irq_n (s2h_irq_n)
    );

    hsirq_h2s #(.NSRC(NSRC)) u_h2s (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl.h2s_we),
        .wdata   (reg_wdata),
        .pulse_o (h2s_pulse)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_STATUS: reg_rdata[NSRC-1:0] = st_q;
            SEL_ENABLE: reg_rdata[NSRC-1:0] = ena_q;
            SEL_H2S:    reg_rdata[NSRC-1:0] = h2s_pulse;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hsirq_bank_chk.sv
module hsirq_bank_chk
    import hsirq_pkg::*;
#(
    parameter int unsigned NSRC = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NSRC-1:0]   reg_wdata,
    input logic              reg_wr,
    input logic [NSRC-1:0]   set_pulse,
    input logic              s2h_irq_n,
    input logic [NSRC-1:0]   h2s_pulse,
    input logic [NSRC-1:0]   st_q,
    input logic [NSRC-1:0]   ena_q
);
    // R2 / R4: a set request is always visible in status afterwards
    p_set_lands_r4: assert property (@(posedge clk) disable iff (rst)
        (|set_pulse) |=> ((st_q & $past(set_pulse)) == $past(set_pulse)));

    // R3: cleared bits without a concurrent set are zero afterwards
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CLEAR) |=> ((st_q & $past(reg_wdata & ~set_pulse)) == '0));

    // R5: enable holds without a write to its address
    p_ena_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == A_ENABLE) |=> $stable(ena_q));

    // R6: line reflects previous cycle's pending state
    p_irq_level_r6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (s2h_irq_n == !(|$past(st_q & ena_q))));

    // R8: no pulse without a write to the host-to-slave byte
    p_h2s_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == A_H2S) |=> (h2s_pulse == '0));

    // R8: pulse carries the written byte
    p_h2s_value_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_H2S) |=> (h2s_pulse == $past(reg_wdata)));
endmodule

bind hsirq_bank hsirq_bank_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .set_pulse (set_pulse),
    .s2h_irq_n (s2h_irq_n),
    .h2s_pulse (h2s_pulse),
    .st_q      (st_q),
    .ena_q     (ena_q)
);

// File: tb/sim_hsirq_bank.sv
`timescale 1ns/1ps
module sim_hsirq_bank;
    localparam logic [11:0] AD_ST  = 12'h058;
    localparam logic [11:0] AD_CLR = 12'h0D4;
    localparam logic [11:0] AD_ENA = 12'h0DC;
    localparam logic [11:0] AD_H2S = 12'h08D;
    localparam logic [11:0] AD_UNM = 12'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_rdata;
    logic [7:0]  set_pulse = '0;
    logic        s2h_irq_n;
    logic [7:0]  h2s_pulse;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_st, m_ena, m_h2s;
    logic       m_irq_n;

    always #5 clk = ~clk;

    hsirq_bank u0 (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rdata (reg_rdata),
        .set_pulse (set_pulse),
        .s2h_irq_n (s2h_irq_n),
        .h2s_pulse (h2s_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] next_status(input logic [7:0] st, input logic clr,
                                               input logic [7:0] d, input logic [7:0] s);
        logic [7:0] r;
        r = clr ? (st & ~d) : st;
        return r | s;
    endfunction

    // One clock of stimulus; model updated at the edge, outputs checked at negedge.
    task automatic step(input logic wr, input logic [11:0] a, input logic [7:0] d,
                        input logic [7:0] s);
        reg_wr = wr; reg_addr = a; reg_wdata = d; set_pulse = s;
        @(posedge clk);
        m_irq_n = ~|(m_st & m_ena);
        m_st    = next_status(m_st, wr && a == AD_CLR, d, s);
        if (wr && a == AD_ENA) m_ena = d;
        m_h2s   = (wr && a == AD_H2S) ? d : 8'h00;
        @(negedge clk);
        reg_wr = 1'b0; set_pulse = '0;
        chk("R6 irq line", {31'd0, s2h_irq_n}, {31'd0, m_irq_n});
        chk("R8 h2s pulse", {24'd0, h2s_pulse}, {24'd0, m_h2s});
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_st = '0; m_ena = '0; m_h2s = '0; m_irq_n = 1'b1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq_n", {31'd0, s2h_irq_n}, 32'd1);
        chk("R1 h2s", {24'd0, h2s_pulse}, 32'd0);
        rd("R1 status", AD_ST, 32'd0);
        rd("R1 enable", AD_ENA, 32'd0);

        // R2 set pulses latch
        step(1'b0, AD_UNM, 8'h00, 8'h05);
        rd("R2 status after set", AD_ST, 32'h05);

        // R10 writes to status / unmapped ignored, reads zero
        step(1'b1, AD_ST, 8'hFF, 8'h00);
        step(1'b1, AD_UNM, 8'hFF, 8'h00);
        rd("R10 status unchanged", AD_ST, 32'h05);
        rd("R10 enable unchanged", AD_ENA, 32'h00);
        rd("R10 unmapped read", AD_UNM, 32'h0);
        rd("R10 clear read", AD_CLR, 32'h0);

        // R5 enable write, R6 line one clock later
        step(1'b1, AD_ENA, 8'h04, 8'h00);
        rd("R5 enable readback", AD_ENA, 32'h04);
        step(1'b0, AD_UNM, 8'h00, 8'h00);
        chk("R6 irq low after enable", {31'd0, s2h_irq_n}, 32'd0);

        // R3 clear with ones and with zeros
        step(1'b1, AD_CLR, 8'h01, 8'h00);
        rd("R3 clear bit0", AD_ST, 32'h04);
        step(1'b1, AD_CLR, 8'h00, 8'h00);
        rd("R3 zero write keeps", AD_ST, 32'h04);

        // R4 set wins over clear on same bit
        step(1'b1, AD_CLR, 8'h04, 8'h04);
        rd("R4 set wins", AD_ST, 32'h04);

        // R7 masking returns line high, status unchanged
        step(1'b1, AD_ENA, 8'h00, 8'h00);
        step(1'b0, AD_UNM, 8'h00, 8'h00);
        chk("R7 irq high when masked", {31'd0, s2h_irq_n}, 32'd1);
        rd("R7 status kept", AD_ST, 32'h04);
        step(1'b1, AD_ENA, 8'hFF, 8'h00);
        step(1'b1, AD_CLR, 8'hFF, 8'h00);
        step(1'b0, AD_UNM, 8'h00, 8'h00);
        chk("R7 irq high when cleared", {31'd0, s2h_irq_n}, 32'd1);

        // R8 / R9 host-to-slave byte
        step(1'b1, AD_H2S, 8'hA5, 8'h00);
        chk("R8 pulse value", {24'd0, h2s_pulse}, 32'hA5);
        rd("R9 read during pulse", AD_H2S, 32'hA5);
        step(1'b0, AD_UNM, 8'h00, 8'h00);
        chk("R8 pulse gone", {24'd0, h2s_pulse}, 32'h0);
        rd("R9 read after clear", AD_H2S, 32'h0);
        step(1'b1, AD_H2S, 8'h00, 8'h00);
        chk("R8 zero write no pulse", {24'd0, h2s_pulse}, 32'h0);

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            logic [7:0]  d, s;
            case ($urandom % 5)
                0: a = AD_ST;
                1: a = AD_CLR;
                2: a = AD_ENA;
                3: a = AD_H2S;
                default: a = AD_UNM;
            endcase
            d = 8'($urandom);
            s = 8'($urandom) & 8'($urandom) & 8'($urandom);
            step(($urandom % 4) != 0, a, d, s);
            rd("R2 random status", AD_ST, {24'd0, m_st});
            rd("R5 random enable", AD_ENA, {24'd0, m_ena});
            rd("R9 random h2s", AD_H2S, {24'd0, m_h2s});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule